// File: doc/BRIEF.md
# Standby Power-Down Sequencer

This block runs on the always-on 32 kHz clock and moves the system into a standby state and back out of it. When an active-low sleep request arrives and standby is enabled, it asserts system reset at once. It then counts a programmable number of slow-clock edges before it drops the auxiliary working-power output. Standby can be enabled by a bit in the block's control register or by an external enable input, and the two behave the same.

A wakeup event reverses the order. The auxiliary power output returns on the same edge that the wakeup is seen. System reset then stays asserted for a second programmable count before it releases. If a wakeup arrives while the power-down countdown is still running, the countdown stops and power is never removed. Both the sleep request and the wakeup input pass through two-flop synchronizers into the 32 kHz domain. The timings below are counted from the edge on which the second synchronizer flop presents the input to the state machine: this is the third rising edge after the input changes.

Two registers are visible through simple write and read strobes. Select 0 is the control word: bit 30 is the standby enable, bits [19:0] are the power-down delay, bit 31 is spare storage, and bits [29:20] read as zero. Select 1 holds the reset-release delay in bits [19:0], and its other bits read as zero.

Top module: `stby_seq`

## Requirements
- R1: After reset both registers read zero, `aux_pwr` is 1 and `sys_rst` is 0.
- R2: In the control word, bits 31, 30 and [19:0] read back the last value written, and bits [29:20] always read 0. In the reset-delay word, bits [19:0] read back the last value written, and bits [31:20] read 0.
- R3: With standby enabled, `sys_rst` rises on the edge at which the synchronized sleep request is first seen (edge E0), whatever the delay value.
- R4: `aux_pwr` falls N edges after E0, where N is the control word's delay field. With N = 0 it falls at E0.
- R5: A 1 on `stby_en_ext` with control bit 30 clear gives the same sequence and delay as control bit 30.
- R6: With both enables clear, a sleep request changes neither `aux_pwr` nor `sys_rst`.
- R7: In standby, `aux_pwr` rises on the edge at which the synchronized wakeup is first seen (edge W0).
- R8: `sys_rst` falls M edges after W0, where M is the reset-delay field. With M = 0 it falls at W0.
- R9: A wakeup seen at or before the edge on which power would drop ends the countdown. `aux_pwr` then stays 1, and `sys_rst` falls M edges after W0.
- R10: Once in standby, only a wakeup event leaves it. Withdrawing the sleep request alone keeps `aux_pwr` at 0 and `sys_rst` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | Register select: 0 control word, 1 reset-delay word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| sleep_n | input | 1 | Sleep request, active low, asynchronous |
| stby_en_ext | input | 1 | External standby enable |
| wake_evt | input | 1 | Wakeup event from the always-on domain, asynchronous |
| aux_pwr | output | 1 | Auxiliary working-power enable |
| sys_rst | output | 1 | System reset for the non-standby logic |

## Verification
The bench predicts the exact cycle of every edge on the two outputs. It goes after the zero-delay cases, where a design with an off-by-one counter would hold power or reset one edge too long. It also sends a wakeup that lands exactly on the edge where power would drop. A design that gives that edge to the countdown instead of the wakeup would drop power for one cycle or get stuck in standby. Further cases withdraw the sleep request inside standby, which a design would wrongly treat as a wakeup, and send a sleep request with no enable set, which a design that ignores the enables would turn into a spurious reset.

// File: rtl/stby_seq.sv
module stby_seq #(
  parameter int DW   = 20,
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        sleep_n,
  input  logic        stby_en_ext,
  input  logic        wake_evt,
  output logic        aux_pwr,
  output logic        sys_rst
);

  localparam int GAP = 30 - DW;

  typedef enum logic [1:0] {ST_RUN, ST_DRAIN, ST_STBY, ST_WAKE} st_t;

  st_t            st;
  logic [DW-1:0]  cnt;
  logic [DW-1:0]  pd_dly;
  logic [DW-1:0]  rel_dly;
  logic           en_bit;
  logic           spare_bit;
  logic [SYNC-1:0] slp_sh;
  logic [SYNC-1:0] wk_sh;
  logic           slp_req;
  logic           wk_req;
  logic           stby_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_sh <= '1;
      wk_sh  <= '0;
    end else begin
      slp_sh <= {slp_sh[SYNC-2:0], sleep_n};
      wk_sh  <= {wk_sh[SYNC-2:0], wake_evt};
    end
  end

  assign slp_req = ~slp_sh[SYNC-1];
  assign wk_req  = wk_sh[SYNC-1];
  assign stby_ok = en_bit | stby_en_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spare_bit <= 1'b0;
      en_bit    <= 1'b0;
      pd_dly    <= '0;
      rel_dly   <= '0;
    end else if (reg_we) begin
      if (reg_sel) begin
        rel_dly <= reg_wdata[DW-1:0];
      end else begin
        spare_bit <= reg_wdata[31];
        en_bit    <= reg_wdata[30];
        pd_dly    <= reg_wdata[DW-1:0];
      end
    end
  end

  assign reg_rdata = reg_sel ? {{(32-DW){1'b0}}, rel_dly}
                             : {spare_bit, en_bit, {GAP{1'b0}}, pd_dly};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_RUN;
      cnt <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          if (slp_req && stby_ok) begin
            if (pd_dly == '0) begin
              st <= ST_STBY;
            end else begin
              st  <= ST_DRAIN;
              cnt <= pd_dly;
            end
          end
        end
        ST_DRAIN: begin
          if (wk_req) begin
            if (rel_dly == '0) begin
              st <= ST_RUN;
            end else begin
              st  <= ST_WAKE;
              cnt <= rel_dly;
            end
          end else if (cnt == DW'(1)) begin
            st <= ST_STBY;
          end else begin
            cnt <= cnt - DW'(1);
          end
        end
        ST_STBY: begin
          if (wk_req) begin
            if (rel_dly == '0) begin
              st <= ST_RUN;
            end else begin
              st  <= ST_WAKE;
              cnt <= rel_dly;
            end
          end
        end
        default: begin
          if (cnt == DW'(1)) begin
            st <= ST_RUN;
          end else begin
            cnt <= cnt - DW'(1);
          end
        end
      endcase
    end
  end

  assign aux_pwr = (st != ST_STBY);
  assign sys_rst = (st != ST_RUN);

  AST_PWR_OFF_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aux_pwr) |-> sys_rst); // R4

  AST_PWR_BEFORE_REL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> aux_pwr); // R8

  AST_WAKE_PWR_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!aux_pwr && wk_req) |=> aux_pwr); // R7

  AST_ABORT_KEEPS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_pwr && sys_rst && wk_req) |=> aux_pwr); // R9

  AST_NO_EN_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && !en_bit && !stby_en_ext) |=> !sys_rst); // R6

  AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!aux_pwr && !wk_req) |=> (!aux_pwr && sys_rst)); // R10

endmodule

// File: tb/test_stby_seq.sv
module test_stby_seq;
  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sleep_n = 1'b1;
  logic        stby_en_ext = 1'b0;
  logic        wake_evt = 1'b0;
  logic        aux_pwr;
  logic        sys_rst;

  typedef struct {
    int    at;
    bit    aux;
    bit    rst;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  logic [1:0] prev = 2'b10;

  stby_seq i_stby_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_n(sleep_n),
    .stby_en_ext(stby_en_ext), .wake_evt(wake_evt),
    .aux_pwr(aux_pwr), .sys_rst(sys_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev = 2'b10;
    end else if ({aux_pwr, sys_rst} != prev) begin
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R6 unexpected output change at cycle %0d: act aux=%0b rst=%0b exp no change",
                 cyc, aux_pwr, sys_rst);
      end else begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (e.at != cyc || e.aux != aux_pwr || e.rst != sys_rst) begin
          n_bad++;
          $display("FAIL %s act cyc=%0d aux=%0b rst=%0b exp cyc=%0d aux=%0b rst=%0b",
                   e.tag, cyc, aux_pwr, sys_rst, e.at, e.aux, e.rst);
        end
      end
      prev = {aux_pwr, sys_rst};
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(bit sel, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_sel = sel;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic push(int at, bit a, bit r, string tag);
    exp_t e;
    e.at = at; e.aux = a; e.rst = r; e.tag = tag;
    q.push_back(e);
  endtask

  // Drive one standby cycle and push the expected output edges.
  task automatic run_seq(bit use_ext, int n, int m, int wgap, int rgap);
    int c, e0, w0;
    bit down;
    wr(1'b0, {1'b0, ~use_ext, 10'd0, 20'(n)});
    wr(1'b1, 32'(m));
    stby_en_ext = use_ext;
    @(negedge clk);
    c = cyc; sleep_n = 1'b0;
    e0 = c + 3; w0 = c + wgap + 3;
    down = (n == 0) || (w0 > e0 + n);
    if (n == 0) push(e0, 1'b0, 1'b1, use_ext ? "R5" : "R4");
    else        push(e0, 1'b1, 1'b1, "R3");
    if (n > 0 && down) push(e0 + n, 1'b0, 1'b1, use_ext ? "R5" : "R4");
    if (down) begin
      if (m == 0) push(w0, 1'b1, 1'b0, "R8");
      else begin
        push(w0, 1'b1, 1'b1, "R7");
        push(w0 + m, 1'b1, 1'b0, "R8");
      end
    end else begin
      push(w0 + m, 1'b1, 1'b0, "R9");
    end
    while (cyc < c + wgap) begin
      @(negedge clk);
      if (cyc == c + rgap) sleep_n = 1'b1;
      if (cyc == c + wgap - 1 && down) begin
        chk("R10 aux in standby", 32'(aux_pwr), 32'd0);
        chk("R10 rst in standby", 32'(sys_rst), 32'd1);
      end
    end
    sleep_n = 1'b1; wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
    while (cyc < w0 + m + 4) @(negedge clk);
    chk("R8 all edges seen", 32'(q.size()), 32'd0);
    stby_en_ext = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired: act running exp finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 aux", 32'(aux_pwr), 32'd1);
    chk("R1 rst", 32'(sys_rst), 32'd0);
    rd_chk(1'b0, 32'h0, "R1 ctrl");
    rd_chk(1'b1, 32'h0, "R1 rel");

    wr(1'b0, 32'hFFFF_FFFF);
    rd_chk(1'b0, 32'hC00F_FFFF, "R2 ctrl all ones");
    wr(1'b1, 32'hFFFF_FFFF);
    rd_chk(1'b1, 32'h000F_FFFF, "R2 rel all ones");
    wr(1'b0, 32'h8001_2345);
    rd_chk(1'b0, 32'h8001_2345, "R2 spare bit");
    wr(1'b0, 32'h0);

    // R6: no enable, sleep request has no effect
    @(negedge clk);
    sleep_n = 1'b0;
    repeat (20) @(negedge clk);
    chk("R6 aux", 32'(aux_pwr), 32'd1);
    chk("R6 rst", 32'(sys_rst), 32'd0);
    sleep_n = 1'b1;
    repeat (5) @(negedge clk);

    run_seq(1'b0, 4, 3, 20, 12);   // R3 R4 R7 R8 R10
    run_seq(1'b0, 0, 0, 10, 6);    // zero delays
    run_seq(1'b1, 6, 2, 18, 18);   // R5
    run_seq(1'b0, 30, 5, 8, 8);    // R9 early wake
    run_seq(1'b0, 5, 1, 5, 5);     // R9 wake on the drop edge
    run_seq(1'b0, 1, 7, 15, 6);    // R10 early release

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule